// File: doc/BRIEF.md
# Register Range Save/Restore Sequencer

This block turns one block-transfer request into a run of single-word memory operations. In save mode it copies an inclusive range of general registers, from a first index up to a last index, into consecutive memory words. In restore mode it loads the same range back from memory. The first word's address is the sum of a displacement and a base value. Each later register uses the next address up.

The surrounding processor decodes the instruction. It then presents the direction, the two register indices, the displacement and the base, and pulses start for one cycle. The sequencer does the rest. It drives a register-file read port and a register-file write port. It also drives a memory port in which read data returns in the same cycle as the address. Each clock moves one word. A one-cycle done pulse tells the processor that the instruction has finished.

Register zero is treated as a constant. When it is the source of a save, the value stored is zero, whatever the register file returns. When it is the destination of a restore, no write is issued.

Top module: `regxfer_seq`

## Requirements
- R1: Save mode (`dir_restore_i` = 0) writes register `first_reg_i`+k to memory address `disp_i`+`base_i`+k, for every k from 0 to `last_reg_i`−`first_reg_i` inclusive. The data is taken from `rf_rdata_i` while `rf_raddr_o` names that register.
- R2: Restore mode (`dir_restore_i` = 1) writes `mem_rdata_i`, read at address `disp_i`+`base_i`+k, into register `first_reg_i`+k over the same inclusive range.
- R3: While `busy_o` is high, exactly one memory transfer happens per clock, and the address rises by one from each cycle to the next. While `busy_o` is low, no memory enable and no register-file write enable is asserted.
- R4: For a range of n registers, `done_o` is high for exactly one cycle, n+1 cycles after the cycle in which start was sampled. `busy_o` is high for exactly n cycles before it.
- R5: If `last_reg_i` is below `first_reg_i`, `done_o` is raised in the cycle after start is sampled and no memory access takes place.
- R6: A restore never writes register 0, so its register-file content stays as it was. A save of register 0 stores the value 0.
- R7: Address arithmetic wraps modulo 2^16, so the word after address 16'hFFFF is 16'h0000.
- R8: A start pulse arriving while `busy_o` is high has no effect on the transfer in progress and does not start a new one.
- R9: After reset the block is idle: `busy_o` and `done_o` are low, and no enable is asserted.
- R10: A save never asserts the register-file write enable, and a restore never asserts the memory write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a transfer |
| dir_restore_i | input | 1 | 0 = save registers to memory, 1 = restore registers from memory |
| first_reg_i | input | 4 | Index of the first register in the range |
| last_reg_i | input | 4 | Index of the last register in the range (inclusive) |
| disp_i | input | 16 | Displacement added to the base |
| base_i | input | 16 | Base address value |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 16 | Register-file read data, same cycle |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 16 | Register-file write data |
| mem_addr_o | output | 16 | Memory word address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data |
| mem_re_o | output | 1 | Memory read enable; read data returns in the same cycle |
| mem_rdata_i | input | 16 | Memory read data |
| busy_o | output | 1 | High during each transfer cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: sixteen 16-bit registers, a 16-bit data path and a 16-bit address. With these values every register index from 0 to 15 can be reached, including the constant register zero. The address can also be carried across the 16'hFFFF to 16'h0000 boundary, because the test sums a large displacement with a small base. Also with these defaults, the register-zero variant is the one generated, so the rule that a restore must not write register 0 and a save of it must store zero is exercised directly.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_RUN  = 2'd1,
      XS_DONE = 2'd2
   } xfer_state_e;

endpackage

// File: rtl/regxfer_ctrl.sv
module regxfer_ctrl
   import regxfer_pkg::*;
#(
   parameter int RIDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_restore_i,
   input  logic [RIDX_W-1:0] first_reg_i,
   input  logic [RIDX_W-1:0] last_reg_i,
   output xfer_state_e       state_o,
   output logic [RIDX_W-1:0] cur_idx_o,
   output logic              dir_q_o,
   output logic              launch_o
);

   xfer_state_e       state_q;
   logic [RIDX_W-1:0] cur_q;
   logic [RIDX_W-1:0] last_q;
   logic              dir_q;
   logic              accept;
   logic              empty_rng;

   // a new request is taken only when no transfer is running
   assign accept    = start_i && (state_q != XS_RUN);
   assign empty_rng = (last_reg_i < first_reg_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cur_q   <= '0;
         last_q  <= '0;
         dir_q   <= 1'b0;
      end else begin
         unique case (state_q)
            XS_RUN: begin
               if (cur_q == last_q) begin
                  state_q <= XS_DONE;
               end else begin
                  cur_q <= cur_q + 1'b1;
               end
            end
            default: begin
               if (accept) begin
                  dir_q   <= dir_restore_i;
                  cur_q   <= first_reg_i;
                  last_q  <= last_reg_i;
                  state_q <= empty_rng ? XS_DONE : XS_RUN;
               end else begin
                  state_q <= XS_IDLE;
               end
            end
         endcase
      end
   end

   assign state_o   = state_q;
   assign cur_idx_o = cur_q;
   assign dir_q_o   = dir_q;
   assign launch_o  = accept;

endmodule

// File: rtl/regxfer_addr_gen.sv
module regxfer_addr_gen #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              step_i,
   input  logic [ADDR_W-1:0] disp_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] addr_o
);

   logic [ADDR_W-1:0] addr_q;

   // sums are kept to ADDR_W bits, so the address wraps at the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (launch_i) begin
         addr_q <= disp_i + base_i;
      end else if (step_i) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/regxfer_route.sv
module regxfer_route #(
   parameter int DATA_W             = 16,
   parameter int RIDX_W             = 4,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input  logic              active_i,
   input  logic              restore_i,
   input  logic [RIDX_W-1:0] cur_idx_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic [RIDX_W-1:0] rf_raddr_o,
   output logic              rf_we_o,
   output logic [RIDX_W-1:0] rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              mem_we_o,
   output logic              mem_re_o,
   output logic [DATA_W-1:0] mem_wdata_o
);

   logic is_const_reg;

   generate
      if (ZERO_REG_HARDWIRED) begin : g_zero_const
         assign is_const_reg = (cur_idx_i == '0);
      end else begin : g_zero_plain
         assign is_const_reg = 1'b0;
      end
   endgenerate

   always_comb begin
      rf_raddr_o  = cur_idx_i;
      rf_waddr_o  = cur_idx_i;
      rf_wdata_o  = mem_rdata_i;
      mem_wdata_o = is_const_reg ? '0 : rf_rdata_i;
      mem_we_o    = active_i && !restore_i;
      mem_re_o    = active_i && restore_i;
      rf_we_o     = active_i && restore_i && !is_const_reg;
   end

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
   import regxfer_pkg::*;
#(
   parameter int REG_CNT            = 16,
   parameter int DATA_W             = 16,
   parameter int ADDR_W             = 16,
   parameter bit ZERO_REG_HARDWIRED = 1'b1,
   localparam int RIDX_W            = $clog2(REG_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_restore_i,
   input  logic [RIDX_W-1:0] first_reg_i,
   input  logic [RIDX_W-1:0] last_reg_i,
   input  logic [ADDR_W-1:0] disp_i,
   input  logic [ADDR_W-1:0] base_i,
   output logic [RIDX_W-1:0] rf_raddr_o,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              rf_we_o,
   output logic [RIDX_W-1:0] rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              mem_we_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              mem_re_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              busy_o,
   output logic              done_o
);

   generate
      if (REG_CNT < 2 || (REG_CNT & (REG_CNT - 1)) != 0) begin : g_bad_reg_cnt
         $error("regxfer_seq: REG_CNT must be a power of two of at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("regxfer_seq: DATA_W must be positive");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("regxfer_seq: ADDR_W must be at least 2");
      end
   endgenerate

   xfer_state_e       state;
   logic [RIDX_W-1:0] cur_idx;
   logic              dir_q;
   logic              launch;
   logic              running;

   regxfer_ctrl #(.RIDX_W(RIDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .dir_restore_i(dir_restore_i),
      .first_reg_i  (first_reg_i),
      .last_reg_i   (last_reg_i),
      .state_o      (state),
      .cur_idx_o    (cur_idx),
      .dir_q_o      (dir_q),
      .launch_o     (launch)
   );

   assign running = (state == XS_RUN);

   regxfer_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch_i(launch),
      .step_i  (running),
      .disp_i  (disp_i),
      .base_i  (base_i),
      .addr_o  (mem_addr_o)
   );

   regxfer_route #(
      .DATA_W            (DATA_W),
      .RIDX_W            (RIDX_W),
      .ZERO_REG_HARDWIRED(ZERO_REG_HARDWIRED)
   ) u_route (
      .active_i   (running),
      .restore_i  (dir_q),
      .cur_idx_i  (cur_idx),
      .rf_rdata_i (rf_rdata_i),
      .mem_rdata_i(mem_rdata_i),
      .rf_raddr_o (rf_raddr_o),
      .rf_we_o    (rf_we_o),
      .rf_waddr_o (rf_waddr_o),
      .rf_wdata_o (rf_wdata_o),
      .mem_we_o   (mem_we_o),
      .mem_re_o   (mem_re_o),
      .mem_wdata_o(mem_wdata_o)
   );

   assign busy_o = running;
   assign done_o = (state == XS_DONE);

endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
   parameter int DATA_W             = 16,
   parameter int ADDR_W             = 16,
   parameter int RIDX_W             = 4,
   parameter bit ZERO_REG_HARDWIRED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              mem_we_o,
   input logic              mem_re_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_wdata_o,
   input logic              rf_we_o,
   input logic [RIDX_W-1:0] rf_waddr_o,
   input logic [RIDX_W-1:0] rf_raddr_o
);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_we_o && !mem_re_o && !rf_we_o));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

   p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_no_r0_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG_HARDWIRED && rf_we_o) |-> (rf_waddr_o != '0));

   p_save_r0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG_HARDWIRED && mem_we_o && rf_raddr_o == '0) |-> (mem_wdata_o == '0));

   p_dir_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && (mem_re_o || rf_we_o)));

endmodule

bind regxfer_seq regxfer_seq_chk #(
   .DATA_W            (DATA_W),
   .ADDR_W            (ADDR_W),
   .RIDX_W            (RIDX_W),
   .ZERO_REG_HARDWIRED(ZERO_REG_HARDWIRED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .mem_we_o   (mem_we_o),
   .mem_re_o   (mem_re_o),
   .mem_addr_o (mem_addr_o),
   .mem_wdata_o(mem_wdata_o),
   .rf_we_o    (rf_we_o),
   .rf_waddr_o (rf_waddr_o),
   .rf_raddr_o (rf_raddr_o)
);

// File: tb/regxfer_seq_bench.sv
`timescale 1ns/100ps
module regxfer_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir = 1'b0;
   logic [3:0]  first_r = '0;
   logic [3:0]  last_r = '0;
   logic [15:0] disp = '0;
   logic [15:0] base = '0;
   logic [3:0]  rf_raddr;
   logic [15:0] rf_rdata;
   logic        rf_we;
   logic [3:0]  rf_waddr;
   logic [15:0] rf_wdata;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic        mem_re;
   logic [15:0] mem_rdata;
   logic        busy;
   logic        done;

   always #2.5 clk = ~clk;

   regxfer_seq u_regxfer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dir_restore_i(dir),
      .first_reg_i(first_r), .last_reg_i(last_r), .disp_i(disp), .base_i(base),
      .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
      .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_addr_o(mem_addr),
      .mem_we_o(mem_we), .mem_wdata_o(mem_wdata), .mem_re_o(mem_re),
      .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done)
   );

   // bench models: register file (raw, R0 not forced) and a 64-word memory window
   logic [15:0] rf_m [16];
   logic [15:0] mem_m [64];
   logic [15:0] wa_log [32];
   int wa_n, re_n, rfw_n;
   int checks = 0, errors = 0;
   bit finished = 1'b0;

   assign rf_rdata  = rf_m[rf_raddr];
   assign mem_rdata = mem_m[mem_addr[5:0]];

   always @(posedge clk) begin
      if (mem_we) begin
         mem_m[mem_addr[5:0]] <= mem_wdata;
         if (wa_n < 32) wa_log[wa_n] <= mem_addr;
         wa_n <= wa_n + 1;
      end
      if (mem_re) re_n <= re_n + 1;
      if (rf_we) begin
         rf_m[rf_waddr] <= rf_wdata;
         rfw_n <= rfw_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clr_logs();
      @(negedge clk);
      wa_n = 0; re_n = 0; rfw_n = 0;
   endtask

   // launches a transfer; returns negedges from start to done and busy cycles seen
   task automatic run_op(input bit d, input logic [3:0] f, input logic [3:0] l,
                         input logic [15:0] dsp, input logic [15:0] bs, input bit inject,
                         output int lat, output int bcnt);
      dir = d; first_r = f; last_r = l; disp = dsp; base = bs; start = 1'b1;
      lat = 0; bcnt = 0;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         if (busy) bcnt++;
         if (inject && lat == 2) begin
            dir = 1'b1; first_r = 4'd0; last_r = 4'd15; disp = 16'h0005; base = 16'h0001;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      @(negedge clk);
      chk(!done, "R4 done lasts one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic t_reset();
      chk(!busy && !done, "R9 busy/done low after reset", {busy, done}, 0);
      chk(!mem_we && !mem_re && !rf_we, "R9 enables low after reset", {mem_we, mem_re, rf_we}, 0);
   endtask

   task automatic t_save_basic();
      int lat, bc;
      clr_logs();
      run_op(1'b0, 4'd3, 4'd9, 16'h0006, 16'h0010, 1'b0, lat, bc);
      chk(wa_n == 7, "R1 save word count", wa_n, 7);
      for (int i = 0; i < 7; i++) begin
         chk(wa_log[i] == 16'h0016 + i, "R1 save address", wa_log[i], 16'h0016 + i);
         chk(mem_m[(6'h16 + i) & 6'h3f] == 16'h1100 + 3 + i, "R1 save data",
             mem_m[(6'h16 + i) & 6'h3f], 16'h1100 + 3 + i);
      end
      chk(lat == 8, "R4 done latency n+1", lat, 8);
      chk(bc == 7, "R3 busy one cycle per word", bc, 7);
      chk(rfw_n == 0 && re_n == 0, "R10 save leaves register file alone", rfw_n + re_n, 0);
   endtask

   task automatic t_restore_basic();
      int lat, bc;
      for (int i = 0; i < 3; i++) mem_m[6'h20 + i] = 16'hA000 + i;
      clr_logs();
      run_op(1'b1, 4'd4, 4'd6, 16'h0020, 16'h0000, 1'b0, lat, bc);
      for (int i = 0; i < 3; i++)
         chk(rf_m[4 + i] == 16'hA000 + i, "R2 restore data", rf_m[4 + i], 16'hA000 + i);
      chk(rf_m[7] == 16'h1107, "R2 register past range untouched", rf_m[7], 16'h1107);
      chk(rf_m[3] == 16'h1103, "R2 register before range untouched", rf_m[3], 16'h1103);
      chk(wa_n == 0, "R10 restore writes no memory", wa_n, 0);
      chk(re_n == 3, "R3 restore read count", re_n, 3);
      chk(lat == 4, "R4 restore latency", lat, 4);
   endtask

   task automatic t_single();
      int lat, bc;
      clr_logs();
      run_op(1'b0, 4'd12, 4'd12, 16'h0001, 16'h0001, 1'b0, lat, bc);
      chk(wa_n == 1 && wa_log[0] == 16'h0002, "R1 single register save", wa_log[0], 16'h0002);
      chk(mem_m[2] == 16'h110C, "R1 single register data", mem_m[2], 16'h110C);
      chk(lat == 2, "R4 single register latency", lat, 2);
   endtask

   task automatic t_empty();
      int lat, bc;
      clr_logs();
      run_op(1'b0, 4'd9, 4'd3, 16'h0000, 16'h0000, 1'b0, lat, bc);
      chk(lat == 1, "R5 empty range done next cycle", lat, 1);
      chk(wa_n == 0 && re_n == 0, "R5 empty range no memory access", wa_n + re_n, 0);
      clr_logs();
      run_op(1'b1, 4'd15, 4'd0, 16'h0000, 16'h0000, 1'b0, lat, bc);
      chk(lat == 1 && bc == 0, "R5 empty restore range", lat, 1);
      chk(rfw_n == 0 && re_n == 0, "R5 empty restore no access", rfw_n + re_n, 0);
   endtask

   task automatic t_zero();
      int lat, bc;
      mem_m[6'h28] = 16'h5550; mem_m[6'h29] = 16'h5551; mem_m[6'h2A] = 16'h5552;
      clr_logs();
      run_op(1'b1, 4'd0, 4'd2, 16'h0028, 16'h0000, 1'b0, lat, bc);
      chk(rf_m[0] == 16'hDEAD, "R6 restore leaves R0 untouched", rf_m[0], 16'hDEAD);
      chk(rf_m[1] == 16'h5551 && rf_m[2] == 16'h5552, "R6 restore of R1..R2", rf_m[2], 16'h5552);
      chk(rfw_n == 2, "R6 register writes skip R0", rfw_n, 2);
      clr_logs();
      run_op(1'b0, 4'd0, 4'd1, 16'h0030, 16'h0000, 1'b0, lat, bc);
      chk(mem_m[6'h30] == 16'h0000, "R6 save of R0 stores zero", mem_m[6'h30], 0);
      chk(mem_m[6'h31] == 16'h5551, "R6 save of R1 after R0", mem_m[6'h31], 16'h5551);
   endtask

   task automatic t_wrap();
      int lat, bc;
      logic [15:0] exp_a [4];
      exp_a[0] = 16'hFFFE; exp_a[1] = 16'hFFFF; exp_a[2] = 16'h0000; exp_a[3] = 16'h0001;
      clr_logs();
      run_op(1'b0, 4'd1, 4'd4, 16'hFFF0, 16'h000E, 1'b0, lat, bc);
      chk(wa_n == 4, "R7 wrap word count", wa_n, 4);
      for (int i = 0; i < 4; i++)
         chk(wa_log[i] == exp_a[i], "R7 address wraps modulo 2^16", wa_log[i], exp_a[i]);
      chk(mem_m[0] == rf_m[3], "R7 data after wrap", mem_m[0], rf_m[3]);
   endtask

   task automatic t_ignore();
      int lat, bc;
      clr_logs();
      run_op(1'b0, 4'd5, 4'd10, 16'h0000, 16'h0038, 1'b1, lat, bc);
      chk(wa_n == 6, "R8 start while busy ignored, word count", wa_n, 6);
      chk(re_n == 0 && rfw_n == 0, "R8 no restore started", re_n + rfw_n, 0);
      chk(wa_log[5] == 16'h003D, "R8 addresses unchanged", wa_log[5], 16'h003D);
      chk(lat == 7, "R8 latency unchanged", lat, 7);
      repeat (3) @(negedge clk);
      chk(!busy && !done, "R8 no later transfer", {busy, done}, 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) rf_m[i] = 16'h1100 + i;
      rf_m[0] = 16'hDEAD;
      for (int i = 0; i < 64; i++) mem_m[i] = 16'h0BAD;
      wa_n = 0; re_n = 0; rfw_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_save_basic();
      t_restore_basic();
      t_single();
      t_empty();
      t_zero();
      t_wrap();
      t_ignore();
      finish_run();
   end

endmodule